// File: doc/BRIEF.md
# Interrupt Return State-Restore Sequencer

This block carries out the return from a user-level interrupt handler in a 64-bit core model. A one-cycle start pulse asks it to run. It first decides whether the return is allowed in the current machine state. If it is not, it reports an invalid-opcode fault at once and does not touch memory.

When the return is allowed, the block reads three 64-bit words from a stack read port, one after another: the return instruction pointer, the saved flags and the saved stack pointer. It then checks that the return address is canonical. When shadow stacks are on, it reads one value from a shadow-stack port and compares it with the return address.

At the end there are two possible outcomes. On success, the block updates the instruction pointer, flags, stack pointer and user-interrupt flag together in one cycle, and clears any armed address monitor. Otherwise it reports exactly one fault. The core that surrounds the block feeds it the current stack pointer and flags, then takes the committed state from its outputs.

Top module: `irq_return_seq`

## Requirements
- R1: If `lock_pfx` or `in_enclave` is 1, or any of `cr_uint_en`, `cpu_has_uint` or `mode_64` is 0, a start gives `done` with `exc`=3'b100 on the clock edge that accepts the start. No stack read is issued and `busy` stays low.
- R2: The three stack reads go to `cur_rsp`, `cur_rsp`+8 and `cur_rsp`+16, in that order. Each one completes on a cycle where `rd_valid` and `rd_ready` are both 1, and `rd_addr` holds its value while `rd_ready` is low. The first word read is the instruction pointer, the second is the flags and the third is the stack pointer.
- R3: With `va57_mode`=0, a return address whose bits 63..47 are not all equal gives `exc`=3'b010, and the committed outputs keep their values.
- R4: With `va57_mode`=1, only bits 63..56 of the return address must all be equal. Bits 55..47 may differ.
- R5: With `shstk_en`=1 and a canonical address, exactly one shadow-stack read is made after the stack reads. A value different from the return address gives `exc`=3'b001. With `shstk_en`=0, or when the address fault is raised, no shadow read is made.
- R6: The committed flags equal (`cur_rflags` & ~64'h254DD5) | (popped flags & 64'h254DD5).
- R7: The committed user-interrupt flag is bit 1 of the popped flags when `uif_from_flags`=1, and 1 otherwise.
- R8: The committed stack pointer is the third word read, not an adjusted `cur_rsp`.
- R9: On success, `new_rip`, `new_rflags`, `new_rsp` and `new_uif` all change on the same edge. On that edge `done`, `commit` and `mon_clr` pulse high for one cycle, and `exc`=0.
- R10: `busy` is high from the cycle after an accepted start until the cycle of `done`. Start pulses that arrive while `busy` is high are ignored.
- R11: `exc` is one-hot or zero: bit 2 is the invalid-opcode fault, bit 1 the general-protection fault and bit 0 the control-protection fault. It is non-zero only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for one return |
| lock_pfx | input | 1 | Lock prefix present |
| in_enclave | input | 1 | Core runs inside an enclave |
| cr_uint_en | input | 1 | Control-register enable for user interrupts |
| cpu_has_uint | input | 1 | User-interrupt feature present |
| mode_64 | input | 1 | Core is in 64-bit mode |
| uif_from_flags | input | 1 | Restore the user-interrupt flag from the popped flags |
| shstk_en | input | 1 | Shadow stack enabled |
| va57_mode | input | 1 | 57-bit virtual addressing |
| cur_rsp | input | 64 | Current stack pointer |
| cur_rflags | input | 64 | Current flags |
| rd_valid | output | 1 | Stack read request |
| rd_addr | output | 64 | Stack read address |
| rd_ready | input | 1 | Stack read accepted, data valid |
| rd_data | input | 64 | Stack read data |
| ss_valid | output | 1 | Shadow-stack read request |
| ss_ready | input | 1 | Shadow-stack read accepted, data valid |
| ss_data | input | 64 | Shadow-stack read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| exc | output | 3 | Fault vector {UD, GP, CP} |
| commit | output | 1 | New state written (one-cycle pulse) |
| mon_clr | output | 1 | Clear the armed address monitor (one-cycle pulse) |
| new_rip | output | 64 | Committed instruction pointer |
| new_rflags | output | 64 | Committed flags |
| new_rsp | output | 64 | Committed stack pointer |
| new_uif | output | 1 | Committed user-interrupt flag |

## Verification
The hardest case to reach from the ports is a return that is both non-canonical and shadow-protected. Both faults are then possible, and only the general-protection fault may appear, with no shadow read at all. A stimulus vector sets the shadow-stack enable together with an out-of-range address and a mismatching shadow value, and the bench counts shadow handshakes as well as checking the fault code. A second hard case is a start pulse that arrives in the middle of a stalled read sequence. A directed test slows the read port down, pulses start with a different stack pointer while reads are pending, and then checks every read address and the count of done pulses.

// File: rtl/irq_return_pkg.sv
package irq_return_pkg;
  localparam int XLEN = 64;
  localparam int NUM_POPS = 3;
  localparam int POP_RIP = 0;
  localparam int POP_FLAGS = 1;
  localparam int POP_SP = 2;

  localparam logic [2:0] EXC_NONE = 3'b000;
  localparam logic [2:0] EXC_UD = 3'b100;
  localparam logic [2:0] EXC_GP = 3'b010;
  localparam logic [2:0] EXC_CP = 3'b001;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POP,
    ST_SHADOW
  } ret_state_e;
endpackage

// File: rtl/irq_ret_canon.sv
module irq_ret_canon #(
  parameter int XLEN = 64,
  parameter int VA_NARROW = 48,
  parameter int VA_WIDE = 57
) (
  input  logic [XLEN-1:0] addr,
  input  logic            wide_va,
  output logic            ok
);
  localparam int NARROW_LSB = VA_NARROW - 1;
  localparam int WIDE_LSB = VA_WIDE - 1;

  logic narrow_ok;
  logic wide_ok;

  // canonical: the sign-extension field above the implemented width is uniform
  assign narrow_ok = (&addr[XLEN-1:NARROW_LSB]) | ~(|addr[XLEN-1:NARROW_LSB]);
  assign wide_ok = (&addr[XLEN-1:WIDE_LSB]) | ~(|addr[XLEN-1:WIDE_LSB]);
  assign ok = wide_va ? wide_ok : narrow_ok;

  // a narrow-canonical address is always wide-canonical
  always_comb begin
    AST_CANON_NEST: assert (!narrow_ok || wide_ok); // R4
  end
endmodule

// File: rtl/irq_ret_flagmerge.sv
module irq_ret_flagmerge #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] MASK = 64'h254DD5,
  parameter int UIF_BIT = 1
) (
  input  logic [XLEN-1:0] old_flags,
  input  logic [XLEN-1:0] popped,
  input  logic            uif_sel,
  output logic [XLEN-1:0] merged,
  output logic            uif_next
);
  // per-bit source pick fixed by the update mask
  for (genvar g = 0; g < XLEN; g++) begin : g_bit
    if (MASK[g]) begin : g_upd
      assign merged[g] = popped[g];
    end else begin : g_keep
      assign merged[g] = old_flags[g];
    end
  end

  assign uif_next = uif_sel ? popped[UIF_BIT] : 1'b1;
endmodule

// File: rtl/irq_ret_popper.sv
module irq_ret_popper #(
  parameter int XLEN = 64,
  parameter int NUM_POPS = 3,
  parameter int STEP = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           launch,
  input  logic [XLEN-1:0]                base,
  input  logic                           rd_ready,
  input  logic [XLEN-1:0]                rd_data,
  output logic                           rd_valid,
  output logic [XLEN-1:0]                rd_addr,
  output logic [NUM_POPS-1:0][XLEN-1:0]  words,
  output logic                           finished
);
  localparam int CW = (NUM_POPS > 1) ? $clog2(NUM_POPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_POPS - 1);

  logic [CW-1:0]   cnt;
  logic            take;
  logic [XLEN-1:0] slot [NUM_POPS];

  assign take = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_addr <= '0;
      cnt <= '0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (launch) begin
        rd_valid <= 1'b1;
        rd_addr <= base;
        cnt <= '0;
      end else if (take) begin
        rd_addr <= rd_addr + XLEN'(STEP);
        if (cnt == LAST) begin
          rd_valid <= 1'b0;
          finished <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_POPS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[g] <= '0;
      end else if (take && cnt == CW'(g)) begin
        slot[g] <= rd_data;
      end
    end
    assign words[g] = slot[g];
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    take |=> (rd_addr == $past(rd_addr) + XLEN'(STEP))); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R2
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    launch |-> !rd_valid); // R10
endmodule

// File: rtl/irq_return_seq.sv
module irq_return_seq
  import irq_return_pkg::*;
#(
  parameter int VA_NARROW = 48,
  parameter int VA_WIDE = 57,
  parameter int POP_STEP = 8,
  parameter logic [63:0] FLAG_MASK = 64'h254DD5,
  parameter int UIF_BIT = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        lock_pfx,
  input  logic        in_enclave,
  input  logic        cr_uint_en,
  input  logic        cpu_has_uint,
  input  logic        mode_64,
  input  logic        uif_from_flags,
  input  logic        shstk_en,
  input  logic        va57_mode,
  input  logic [63:0] cur_rsp,
  input  logic [63:0] cur_rflags,
  output logic        rd_valid,
  output logic [63:0] rd_addr,
  input  logic        rd_ready,
  input  logic [63:0] rd_data,
  output logic        ss_valid,
  input  logic        ss_ready,
  input  logic [63:0] ss_data,
  output logic        busy,
  output logic        done,
  output logic [2:0]  exc,
  output logic        commit,
  output logic        mon_clr,
  output logic [63:0] new_rip,
  output logic [63:0] new_rflags,
  output logic [63:0] new_rsp,
  output logic        new_uif
);
  ret_state_e state;

  logic        ud_hit;
  logic        accept;
  logic        launch;
  logic        pop_done;
  logic        canon_ok;
  logic        uif_next;
  logic [63:0] merged_flags;
  logic [NUM_POPS-1:0][XLEN-1:0] words;

  logic [63:0] old_flags_q;
  logic        uif_sel_q;
  logic        shstk_q;
  logic        va57_q;

  assign ud_hit = lock_pfx | in_enclave | ~cr_uint_en | ~cpu_has_uint | ~mode_64;
  assign accept = start & (state == ST_IDLE);
  assign launch = accept & ~ud_hit;
  assign ss_valid = (state == ST_SHADOW);

  irq_ret_popper #(
    .XLEN(XLEN),
    .NUM_POPS(NUM_POPS),
    .STEP(POP_STEP)
  ) u_pop (
    .clk(clk),
    .rst(rst),
    .launch(launch),
    .base(cur_rsp),
    .rd_ready(rd_ready),
    .rd_data(rd_data),
    .rd_valid(rd_valid),
    .rd_addr(rd_addr),
    .words(words),
    .finished(pop_done)
  );

  irq_ret_canon #(
    .XLEN(XLEN),
    .VA_NARROW(VA_NARROW),
    .VA_WIDE(VA_WIDE)
  ) u_canon (
    .addr(words[POP_RIP]),
    .wide_va(va57_q),
    .ok(canon_ok)
  );

  irq_ret_flagmerge #(
    .XLEN(XLEN),
    .MASK(FLAG_MASK),
    .UIF_BIT(UIF_BIT)
  ) u_merge (
    .old_flags(old_flags_q),
    .popped(words[POP_FLAGS]),
    .uif_sel(uif_sel_q),
    .merged(merged_flags),
    .uif_next(uif_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
      exc <= EXC_NONE;
      commit <= 1'b0;
      mon_clr <= 1'b0;
      new_rip <= '0;
      new_rflags <= '0;
      new_rsp <= '0;
      new_uif <= 1'b0;
      old_flags_q <= '0;
      uif_sel_q <= 1'b0;
      shstk_q <= 1'b0;
      va57_q <= 1'b0;
    end else begin
      done <= 1'b0;
      exc <= EXC_NONE;
      commit <= 1'b0;
      mon_clr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (ud_hit) begin
              done <= 1'b1;
              exc <= EXC_UD;
            end else begin
              state <= ST_POP;
              busy <= 1'b1;
              old_flags_q <= cur_rflags;
              uif_sel_q <= uif_from_flags;
              shstk_q <= shstk_en;
              va57_q <= va57_mode;
            end
          end
        end
        ST_POP: begin
          if (pop_done) begin
            if (!canon_ok) begin
              state <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
              exc <= EXC_GP;
            end else if (shstk_q) begin
              state <= ST_SHADOW;
            end else begin
              state <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
              commit <= 1'b1;
              mon_clr <= 1'b1;
              new_rip <= words[POP_RIP];
              new_rflags <= merged_flags;
              new_rsp <= words[POP_SP];
              new_uif <= uif_next;
            end
          end
        end
        ST_SHADOW: begin
          if (ss_ready) begin
            state <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
            if (ss_data != words[POP_RIP]) begin
              exc <= EXC_CP;
            end else begin
              commit <= 1'b1;
              mon_clr <= 1'b1;
              new_rip <= words[POP_RIP];
              new_rflags <= merged_flags;
              new_rsp <= words[POP_SP];
              new_uif <= uif_next;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          busy <= 1'b0;
        end
      endcase
    end
  end

  AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(exc)); // R11
  AST_EXC_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (exc != EXC_NONE) |-> done); // R11
  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    commit |-> (done && mon_clr && exc == EXC_NONE)); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && exc != EXC_NONE) |-> ($stable(new_rip) && $stable(new_rsp) && $stable(new_rflags))); // R3
  AST_UD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done && exc == EXC_UD) |-> (!busy && !rd_valid)); // R1
  AST_SS_GATED: assert property (@(posedge clk) disable iff (rst)
    ss_valid |-> (shstk_q && busy && !rd_valid)); // R5
  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> !done); // R10
endmodule

// File: tb/sim_irq_return_seq.sv
module sim_irq_return_seq;
  localparam logic [63:0] MASK = 64'h254DD5;
  localparam logic [63:0] OLD_FL = 64'hA5A5_0000_00DA_B22A;

  typedef struct packed {
    logic [7:0]  ctl;   // lock encl cren feat lm64 shstk va57 uifsel
    logic [63:0] rip;
    logic [63:0] fl;
    logic [63:0] sp;
    logic [63:0] ss;
    logic [2:0]  exc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{8'h38, 64'h0000_7FFF_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_7FFF_F000_0100, 64'h0, 3'b000},
    '{8'h39, 64'hFFFF_8000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_2000, 64'h0, 3'b000},
    '{8'hB8, 64'h0000_0000_0000_1000, 64'h0, 64'h0, 64'h0, 3'b100},
    '{8'h78, 64'h0000_0000_0000_1000, 64'h0, 64'h0, 64'h0, 3'b100},
    '{8'h18, 64'h0000_0000_0000_1000, 64'h0, 64'h0, 64'h0, 3'b100},
    '{8'h28, 64'h0000_0000_0000_1000, 64'h0, 64'h0, 64'h0, 3'b100},
    '{8'h30, 64'h0000_0000_0000_1000, 64'h0, 64'h0, 64'h0, 3'b100},
    '{8'h38, 64'h0000_8000_0000_0000, 64'h0000_0000_0025_4DD5, 64'h0000_0000_0000_3000, 64'h0, 3'b010},
    '{8'h3A, 64'h0000_8000_0000_0000, 64'h0000_0000_0012_3456, 64'h0000_0000_0000_4000, 64'h0, 3'b000},
    '{8'h3A, 64'h0100_0000_0000_0000, 64'h0, 64'h0, 64'h0, 3'b010},
    '{8'h3C, 64'h0000_1234_5678_9AB0, 64'h0000_0000_0000_0ED7, 64'h0000_0000_0000_5008, 64'h0000_1234_5678_9AB0, 3'b000},
    '{8'h3C, 64'h0000_1234_5678_9AB0, 64'h0, 64'h0000_0000_0000_6000, 64'h0000_1234_5678_9AB8, 3'b001},
    '{8'h3C, 64'h0001_0000_0000_0000, 64'h0, 64'h0, 64'h0000_0000_0000_0000, 3'b010},
    '{8'h39, 64'h0000_0000_0040_0000, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_7000, 64'h0, 3'b000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        lock_pfx = 1'b0, in_enclave = 1'b0, cr_uint_en = 1'b0, cpu_has_uint = 1'b0;
  logic        mode_64 = 1'b0, uif_from_flags = 1'b0, shstk_en = 1'b0, va57_mode = 1'b0;
  logic [63:0] cur_rsp = '0, cur_rflags = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [63:0] rd_addr, rd_data;
  logic        ss_valid, ss_ready = 1'b0;
  logic [63:0] ss_data;
  logic        busy, done, commit, mon_clr, new_uif;
  logic [2:0]  exc;
  logic [63:0] new_rip, new_rflags, new_rsp;

  logic [63:0] base = '0, w0 = '0, w1 = '0, w2 = '0, ssv = '0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign rd_data = (rd_addr == base) ? w0 :
                   (rd_addr == base + 64'd8) ? w1 :
                   (rd_addr == base + 64'd16) ? w2 : 64'hBAD0_BAD0_BAD0_BAD0;
  assign ss_data = ssv;

  irq_return_seq u0 (
    .clk(clk), .rst(rst), .start(start),
    .lock_pfx(lock_pfx), .in_enclave(in_enclave), .cr_uint_en(cr_uint_en),
    .cpu_has_uint(cpu_has_uint), .mode_64(mode_64), .uif_from_flags(uif_from_flags),
    .shstk_en(shstk_en), .va57_mode(va57_mode),
    .cur_rsp(cur_rsp), .cur_rflags(cur_rflags),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .ss_valid(ss_valid), .ss_ready(ss_ready), .ss_data(ss_data),
    .busy(busy), .done(done), .exc(exc), .commit(commit), .mon_clr(mon_clr),
    .new_rip(new_rip), .new_rflags(new_rflags), .new_rsp(new_rsp), .new_uif(new_uif)
  );

  task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx, input bit stall, input bit restart_mid);
    logic [63:0] p_rip, p_fl, p_sp;
    logic [2:0]  got_exc;
    logic        got_commit, got_mon, got_done;
    int reads, ssreads, done_at, tick;
    logic [63:0] e_fl;
    logic        e_uif, e_ud;
    @(negedge clk);
    {lock_pfx, in_enclave, cr_uint_en, cpu_has_uint, mode_64, shstk_en, va57_mode, uif_from_flags} = v.ctl;
    base = 64'h0000_0000_0010_0000 + 64'(idx) * 64'h100;
    cur_rsp = base;
    cur_rflags = OLD_FL;
    w0 = v.rip; w1 = v.fl; w2 = v.sp; ssv = v.ss;
    p_rip = new_rip; p_fl = new_rflags; p_sp = new_rsp;
    e_ud = (v.exc == 3'b100);
    start = 1'b1;
    reads = 0; ssreads = 0; done_at = -1; got_done = 1'b0;
    got_exc = '0; got_commit = 1'b0; got_mon = 1'b0; tick = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      start = (restart_mid && n == 2);
      if (restart_mid && n == 2) cur_rsp = base + 64'h5000;
      if (n == 0 && !e_ud) chk("R10 busy after start", busy == 1'b1, 64'(busy), 64'd1);
      if (done) begin
        got_done = 1'b1; done_at = n; got_exc = exc;
        got_commit = commit; got_mon = mon_clr;
        rd_ready = 1'b0; ss_ready = 1'b0;
        break;
      end
      if (rd_valid) begin
        chk("R2 read address order", rd_addr == base + 64'(reads) * 64'd8, rd_addr, base + 64'(reads) * 64'd8);
        tick++;
        rd_ready = stall ? tick[0] : 1'b1;
        if (rd_ready) reads++;
      end else begin
        rd_ready = 1'b0;
      end
      ss_ready = ss_valid;
      if (ss_valid) ssreads++;
    end
    start = 1'b0;
    if (!got_done) begin
      fails++; checks++;
      $display("FAIL watchdog R10 vector %0d actual=no_done expected=done", idx);
      return;
    end
    chk("R11 exception code", got_exc == v.exc, 64'(got_exc), 64'(v.exc));
    chk("R1 R2 stack read count", reads == (e_ud ? 0 : 3), 64'(reads), e_ud ? 64'd0 : 64'd3);
    chk("R5 shadow read count", ssreads == ((v.ctl[2] && (v.exc == 3'b000 || v.exc == 3'b001)) ? 1 : 0),
        64'(ssreads), (v.ctl[2] && (v.exc == 3'b000 || v.exc == 3'b001)) ? 64'd1 : 64'd0);
    if (e_ud) chk("R1 fault on accept edge", done_at == 0, 64'(done_at), 64'd0);
    chk("R9 commit pulse", got_commit == (v.exc == 3'b000), 64'(got_commit), 64'(v.exc == 3'b000));
    chk("R9 monitor clear", got_mon == (v.exc == 3'b000), 64'(got_mon), 64'(v.exc == 3'b000));
    if (v.exc == 3'b000) begin
      e_fl = (OLD_FL & ~MASK) | (v.fl & MASK);
      e_uif = v.ctl[0] ? v.fl[1] : 1'b1;
      chk("R2 R4 committed rip", new_rip == v.rip, new_rip, v.rip);
      chk("R6 merged flags", new_rflags == e_fl, new_rflags, e_fl);
      chk("R8 committed rsp", new_rsp == v.sp, new_rsp, v.sp);
      chk("R7 interrupt flag", new_uif == e_uif, 64'(new_uif), 64'(e_uif));
    end else begin
      chk("R3 rip held on fault", new_rip == p_rip, new_rip, p_rip);
      chk("R3 flags held on fault", new_rflags == p_fl, new_rflags, p_fl);
      chk("R3 rsp held on fault", new_rsp == p_sp, new_rsp, p_sp);
    end
    @(negedge clk);
    chk("R11 exc cleared after done", exc == 3'b000 && !done, 64'(exc), 64'd0);
    if (restart_mid) begin
      for (int k = 0; k < 6; k++) begin
        chk("R10 no second done", !done && !rd_valid, 64'(done), 64'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset busy", busy == 1'b0, 64'(busy), 64'd0);
    chk("R11 reset done/exc", done == 1'b0 && exc == 3'b000, 64'(exc), 64'd0);
    chk("R9 reset outputs", new_rip == '0 && new_rsp == '0 && !commit && !mon_clr, new_rip, 64'd0);
    chk("R2 reset no read", rd_valid == 1'b0 && ss_valid == 1'b0, 64'(rd_valid), 64'd0);
    for (int i = 0; i < NV; i++) run_vec(VT[i], i, i[0], 1'b0);
    // restart during a stalled sequence with shadow check
    run_vec(VT[10], 20, 1'b1, 1'b1);
    // back-to-back successful return after the ignored start
    run_vec(VT[13], 21, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule